// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns a noisy, active-low external reset pin into the internal resets of a chip. It runs a free-running, slow filter clock that never stops. On that clock the pin is synchronised and debounced: a level change counts only after it has held for a set number of consecutive filter-clock samples. The debounced level drives `rst_n_async`. This output acts on its own, with no edge of the main clock, so port state is forced while the main clock is still stopped.

Once the debounced reset lets go, the block raises `osc_en` to start the main oscillator. The oscillator is not part of this block. A release chain clocked by the main clock then shifts in ones and counts settle cycles before it raises `rst_n_sync`. That output therefore rises cleanly on a main-clock edge, and only after the clock is known to run. If the pin sits low from power-up, every output stays in reset. No pin edge is needed for this, because each register starts from its asserted value.

Top module: `reset_sequencer`

## Requirements
- R1: A low pulse on `pin_rst_n` that is shorter than `FILT_SAMPLES` consecutive filter-clock samples (default 5 samples of 10 ns, so about 50 ns) leaves `rst_n_async`, `osc_en` and `rst_n_sync` at 1.
- R2: A low level on `pin_rst_n` held longer than the filter window drives `rst_n_async` to 0. No main-clock edge is needed for this.
- R3: If `pin_rst_n` is low from power-up and no edge has ever been seen on it, all three outputs read 0 and the main clock never starts.
- R4: Release is filtered as well. `rst_n_async` rises only after the pin has been high for `FILT_SAMPLES` consecutive samples, so a short high glitch during reset is ignored.
- R5: `osc_en` is 0 whenever `rst_n_async` is 0. It rises on the first filter-clock edge after `rst_n_async` rises.
- R6: `rst_n_sync` is cleared at once when `rst_n_async` falls, with no main-clock edge.
- R7: After `osc_en` rises, `rst_n_sync` rises exactly on main-clock rising edge number `SYNC_STAGES + SETTLE_CYCLES + 1`. With the defaults of 2 and 8, that is edge 11.
- R8: `rst_n_sync` is never 1 while `osc_en` is 0.
- R9: Once `rst_n_sync` is 1, it stays 1 until `rst_n_async` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| filt_clk | input | 1 | Free-running slow clock that samples the pin |
| clk | input | 1 | Main clock from the oscillator; runs only while `osc_en` is 1 |
| pin_rst_n | input | 1 | External reset pin, active low, may bounce |
| rst_n_async | output | 1 | Debounced reset, active low, acts without any main-clock edge |
| osc_en | output | 1 | Oscillator enable |
| rst_n_sync | output | 1 | Internal reset, active low, released on a main-clock edge |

## Verification
The embedded assertions check four rules on every edge. The debounced state flips only after a full run of differing samples. The oscillator enable and the synchronised reset are both low whenever the debounced reset is low. The synchronised reset never rises without the oscillator enable and never drops while the debounced reset is high. The directed scenarios cover what a property cannot see. These are the power-up case with the pin held low and the main clock never toggling, the rejection of short pulses in both directions, and the exact main-clock edge on which release arrives.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;
  function automatic int cnt_width(input int max_value);
    return (max_value < 2) ? 1 : $clog2(max_value + 1);
  endfunction
endpackage

// File: rtl/pin_debounce.sv
module pin_debounce #(
  parameter int SAMPLES     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic filt_clk,
  input  logic pin_n,
  output logic level_n
);
  import reset_seq_pkg::*;
  localparam int CW = cnt_width(SAMPLES);
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  // Power-on value of every register is the asserted (low) state.
  logic [SYNC_STAGES-1:0] smp = '0;
  logic [CW-1:0]          run = '0;
  logic                   state = 1'b0;
  logic                   cur;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge filt_clk) smp <= pin_n;
    end else begin : g_chain
      always_ff @(posedge filt_clk) smp <= {smp[SYNC_STAGES-2:0], pin_n};
    end
  endgenerate

  assign cur = smp[SYNC_STAGES-1];

  always_ff @(posedge filt_clk) begin
    if (cur == state) begin
      run <= '0;
    end else if (run == LAST) begin
      state <= cur;
      run   <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign level_n = state;

  // R1: state holds unless a full run of differing samples completed
  assert_no_early_flip_R1: assert property (@(posedge filt_clk)
    (cur == state || run != LAST) |=> $stable(level_n));
  // R4: a completed high run releases the debounced reset
  assert_release_after_run_R4: assert property (@(posedge filt_clk)
    (!state && cur && run == LAST) |=> level_n);
endmodule

// File: rtl/osc_gate.sv
module osc_gate (
  input  logic filt_clk,
  input  logic arst_n,
  output logic osc_en
);
  logic en_q = 1'b0;

  always_ff @(posedge filt_clk or negedge arst_n) begin
    if (!arst_n) en_q <= 1'b0;
    else         en_q <= 1'b1;
  end

  assign osc_en = en_q;

  // R5: enable is off whenever the debounced reset is asserted
  assert_osc_off_in_reset_R5: assert property (@(posedge filt_clk)
    !arst_n |-> !osc_en);
endmodule

// File: rtl/release_sync.sv
module release_sync #(
  parameter int STAGES        = 2,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_n
);
  import reset_seq_pkg::*;
  localparam int CW = cnt_width(SETTLE_CYCLES);
  localparam logic [CW-1:0] DONE = CW'(SETTLE_CYCLES);

  logic [STAGES-1:0] chain = '0;
  logic [CW-1:0]     settle = '0;
  logic              rel_q = 1'b0;
  logic              ready;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign ready = chain[STAGES-1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      settle <= '0;
      rel_q  <= 1'b0;
    end else begin
      if (ready && settle != DONE) settle <= settle + 1'b1;
      rel_q <= ready && (settle == DONE);
    end
  end

  assign rel_n = rel_q;

  // R9: once released, stays released while the debounced reset is high
  assert_release_holds_R9: assert property (@(posedge clk) disable iff (!arst_n)
    rel_n |=> rel_n);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int FILT_SAMPLES  = 5,
  parameter int PIN_SYNC      = 2,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic filt_clk,
  input  logic clk,
  input  logic pin_rst_n,
  output logic rst_n_async,
  output logic osc_en,
  output logic rst_n_sync
);
  pin_debounce #(.SAMPLES(FILT_SAMPLES), .SYNC_STAGES(PIN_SYNC)) u_debounce (
    .filt_clk (filt_clk),
    .pin_n    (pin_rst_n),
    .level_n  (rst_n_async)
  );

  osc_gate u_osc (
    .filt_clk (filt_clk),
    .arst_n   (rst_n_async),
    .osc_en   (osc_en)
  );

  release_sync #(.STAGES(SYNC_STAGES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_release (
    .clk    (clk),
    .arst_n (rst_n_async),
    .rel_n  (rst_n_sync)
  );

  // R6: internal reset is low whenever the debounced reset is low
  assert_sync_low_in_reset_R6: assert property (@(posedge filt_clk)
    !rst_n_async |-> !rst_n_sync);
  // R8: release never without a running oscillator
  assert_osc_before_release_R8: assert property (@(posedge filt_clk)
    rst_n_sync |-> osc_en);
endmodule

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;
  localparam int FS = 5, PS = 2, SS = 2, ST = 8;
  localparam int REL_EDGE = SS + ST + 1;

  logic filt_clk = 1'b0;
  logic clk = 1'b0;
  logic pin_rst_n = 1'b0;
  logic rst_n_async, osc_en, rst_n_sync;
  int   checks = 0, errors = 0, clk_edges = 0;
  bit   done = 0;

  reset_sequencer #(.FILT_SAMPLES(FS), .PIN_SYNC(PS), .SYNC_STAGES(SS),
                    .SETTLE_CYCLES(ST)) u_reset_sequencer (
    .filt_clk(filt_clk), .clk(clk), .pin_rst_n(pin_rst_n),
    .rst_n_async(rst_n_async), .osc_en(osc_en), .rst_n_sync(rst_n_sync));

  always #5 filt_clk = ~filt_clk;

  // Oscillator model: 50 MHz, runs only while enabled
  always begin
    if (osc_en) begin
      #10 clk = 1'b1;
      #10 clk = 1'b0;
    end else begin
      @(osc_en);
    end
  end

  always @(posedge clk) clk_edges++;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_rise_async(input string req);
    int n = 0;
    while (rst_n_async !== 1'b1 && n < 100) begin #5; n++; end
    chk(req, rst_n_async, 1'b1);
  endtask

  // R5, R7, R8: enable follows release; sync release on a fixed main-clock edge
  task automatic t_sequence(input string tag);
    @(posedge rst_n_async); #1;
    chk({tag, " R5 osc_en still off at release"}, osc_en, 1'b0);
    @(posedge filt_clk); #1;
    chk({tag, " R5 osc_en on after one filter edge"}, osc_en, 1'b1);
    for (int i = 1; i <= REL_EDGE; i++) begin
      @(posedge clk); #1;
      if (i == REL_EDGE - 1)
        chk({tag, " R7 still held one edge before"}, rst_n_sync, 1'b0);
      if (i == REL_EDGE)
        chk({tag, " R7 released on target edge"}, rst_n_sync, 1'b1);
      if (rst_n_sync && !osc_en)
        chk({tag, " R8 release without osc"}, 1'b1, 1'b0);
    end
  endtask

  task automatic t_powerup;
    #300;
    chk("R3 rst_n_async low at power-up", rst_n_async, 1'b0);
    chk("R3 osc_en low at power-up", osc_en, 1'b0);
    chk("R3 rst_n_sync low at power-up", rst_n_sync, 1'b0);
    chk_int("R3 main clock never started", clk_edges, 0);
  endtask

  task automatic t_release_glitch;
    @(posedge filt_clk); #2;
    pin_rst_n = 1'b1; #20; pin_rst_n = 1'b0;
    #200;
    chk("R4 short high glitch ignored", rst_n_async, 1'b0);
    chk_int("R4 clock still stopped", clk_edges, 0);
    pin_rst_n = 1'b1;
    #30;
    chk("R4 release not before window", rst_n_async, 1'b0);
  endtask

  task automatic t_short_pulse;
    #400;
    chk("R9 released and holding", rst_n_sync, 1'b1);
    @(posedge filt_clk); #2;
    pin_rst_n = 1'b0; #20; pin_rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #60;
      chk("R1 short low pulse ignored (async)", rst_n_async, 1'b1);
      chk("R1 short low pulse ignored (sync)", rst_n_sync, 1'b1);
    end
    chk("R1 osc_en kept", osc_en, 1'b1);
  endtask

  task automatic t_long_pulse;
    int n = 0;
    int snap;
    @(posedge filt_clk); #2;
    pin_rst_n = 1'b0;
    while (rst_n_async !== 1'b0 && n < 40) begin #5; n++; end
    chk("R2 long low asserts reset", rst_n_async, 1'b0);
    #1;
    chk("R6 rst_n_sync cleared at once", rst_n_sync, 1'b0);
    chk("R5 osc_en cleared in reset", osc_en, 1'b0);
    #25;
    snap = clk_edges;
    #300;
    chk_int("R2 no main-clock edges while in reset", clk_edges, snap);
    chk("R6 rst_n_sync held with clock stopped", rst_n_sync, 1'b0);
    pin_rst_n = 1'b1;
  endtask

  initial begin
    t_powerup();
    t_release_glitch();
    fork
      t_sequence("first");
      wait_rise_async("R4 release after window");
    join
    t_short_pulse();
    t_long_pulse();
    t_sequence("second");
    for (int i = 0; i < 5; i++) begin
      #100;
      chk("R9 release stays high", rst_n_sync, 1'b1);
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule